// File: doc/BRIEF.md
# PCI Interrupt Router and Processor Trigger

This block takes interrupt events raised by devices on a PCI bus and turns each one into an internal interrupt number. The number depends on the slot the device sits in and on which of its four interrupt pins (A to D, coded 0 to 3) fired. Two slots have one fixed line each. The shared multi-function slot keeps its four pins apart. The expansion slots rotate their pins, so that neighbouring cards spread over different lines. Any slot outside these ranges is passed through without translation.

Numbers from the internal base (32) up to base + 31 address one internal line each. For that line, two configuration vectors decide how the processor interrupt is driven:
- If the line's edge bit is set, the event gives a one-clock pulse.
- Otherwise the line's polarity bit is copied onto the processor interrupt, and it holds there until the next event that counts.

Every event also shows the mapped number on a registered output, one clock later.

Top module: `pci_irq_router`

## Requirements
- R1: During and right after a synchronous reset, `map_valid_o`, `map_num_o` and `cpu_irq_o` are all 0.
- R2: The slot is `evt_devfn_i[7:3]`. One clock after a cycle with `evt_valid_i` high, `map_valid_o` is 1 and `map_num_o` holds that event's number. After a cycle without an event, `map_valid_o` is 0.
- R3: Slot 5 maps pin p (0..3) to 32 + p.
- R4: Slot 6 maps to 36 and slot 7 maps to 37, for every pin.
- R5: Slots 8 to 12 map pin p to (slot - 8) + p + 38. Slot 12 with pin 3 gives 45.
- R6: Every other slot maps pin p to p.
- R7: An event whose number n lies in 32..63, with `edge_cfg_i[n-32]` = 1, drives `cpu_irq_o` to 1 for exactly the next clock. It then falls to 0, unless another such event follows directly.
- R8: An event in 32..63 whose edge bit is 0 sets `cpu_irq_o` to `pol_cfg_i[n-32]` one clock later. The output holds that value until the next event in range.
- R9: An event whose number is outside 32..63 does not change `cpu_irq_o`. A pulse that is already in progress still ends on schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_valid_i | input | 1 | An interrupt event is presented this cycle |
| evt_devfn_i | input | 8 | Device/function code of the source; bits 7:3 are the slot |
| evt_pin_i | input | 2 | Interrupt pin of the source, 0 = A .. 3 = D |
| edge_cfg_i | input | 32 | Per internal line: 1 = pulse, 0 = level |
| pol_cfg_i | input | 32 | Per internal line: level driven in level mode |
| map_valid_o | output | 1 | Registered: a mapped number is shown |
| map_num_o | output | 8 | Registered mapped interrupt number |
| cpu_irq_o | output | 1 | Registered processor interrupt drive |

## Verification
The mapping is swept over all 32 slot codes and all four pins with random function bits. This separates the fixed slots, the pin rotation on the expansion slots and the pass-through of unknown slots.

Trigger behaviour is exercised in four situations:
- A level line set high and then low, with idle cycles in between to show that the level holds.
- A single pulse, to check that it lasts one clock.
- Back-to-back pulse events, to show that the output stays high across them.
- Untranslated events placed after a held level and straight after a pulse, to show that they neither change the line nor stretch the pulse.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // What an event asks of the processor interrupt line.
  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,   // number outside the internal window
    TRIG_LEVEL = 2'd1,   // drive the polarity bit and hold it
    TRIG_PULSE = 2'd2    // single-clock pulse
  } trig_kind_e;

  typedef struct packed {
    trig_kind_e kind;
    logic       level;
  } trig_req_t;

endpackage

// File: rtl/irq_slot_mapper.sv
module irq_slot_mapper #(
  parameter int DEVFN_W    = 8,
  parameter int PIN_W      = 2,
  parameter int NUM_W      = 8,
  parameter int IRQ_BASE   = 32,
  parameter int MF_SLOT    = 5,   // multi-function slot, pins kept apart
  parameter int FIX0_SLOT  = 6,   // single fixed line
  parameter int FIX0_LINE  = 4,
  parameter int FIX1_SLOT  = 7,
  parameter int FIX1_LINE  = 5,
  parameter int EXP_FIRST  = 8,   // rotated expansion slots
  parameter int EXP_LAST   = 12,
  parameter int EXP_LINE0  = 6
) (
  input  logic [DEVFN_W-1:0] devfn_i,
  input  logic [PIN_W-1:0]   pin_i,
  output logic [NUM_W-1:0]   num_o
);

  localparam int SLOT_W = DEVFN_W - 3;

  logic [SLOT_W-1:0] slot;
  logic [NUM_W-1:0]  pin_ext;
  logic [NUM_W-1:0]  slot_ext;

  assign slot     = devfn_i[DEVFN_W-1:3];
  assign pin_ext  = NUM_W'(pin_i);
  assign slot_ext = NUM_W'(slot);

  always_comb begin
    if (int'(slot) == MF_SLOT) begin
      // pin width is the modulus: four pins, four lines
      num_o = NUM_W'(IRQ_BASE) + pin_ext;
    end else if (int'(slot) == FIX0_SLOT) begin
      num_o = NUM_W'(IRQ_BASE + FIX0_LINE);
    end else if (int'(slot) == FIX1_SLOT) begin
      num_o = NUM_W'(IRQ_BASE + FIX1_LINE);
    end else if (int'(slot) >= EXP_FIRST && int'(slot) <= EXP_LAST) begin
      num_o = slot_ext - NUM_W'(EXP_FIRST) + pin_ext + NUM_W'(IRQ_BASE + EXP_LINE0);
    end else begin
      num_o = pin_ext;
    end
  end

endmodule

// File: rtl/irq_line_decode.sv
module irq_line_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int NUM_INT  = 32
) (
  input  logic [NUM_W-1:0]   num_i,
  input  logic [NUM_INT-1:0] edge_cfg_i,
  input  logic [NUM_INT-1:0] pol_cfg_i,
  output trig_req_t          req_o
);

  localparam int IDX_W = (NUM_INT > 1) ? $clog2(NUM_INT) : 1;

  logic             in_window;
  logic [NUM_W-1:0] offset;
  logic [IDX_W-1:0] idx;

  assign in_window = (int'(num_i) >= IRQ_BASE) && (int'(num_i) < IRQ_BASE + NUM_INT);
  assign offset    = num_i - NUM_W'(IRQ_BASE);
  assign idx       = offset[IDX_W-1:0];

  always_comb begin
    req_o.level = pol_cfg_i[idx];
    if (!in_window)           req_o.kind = TRIG_NONE;
    else if (edge_cfg_i[idx]) req_o.kind = TRIG_PULSE;
    else                      req_o.kind = TRIG_LEVEL;
  end

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import irq_route_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fire_i,
  input  trig_req_t req_i,
  output logic      irq_o
);

  logic irq_q;
  logic pulse_q;
  logic act;

  assign act = fire_i && (req_i.kind != TRIG_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (act) begin
      if (req_i.kind == TRIG_PULSE) begin
        irq_q   <= 1'b1;
        pulse_q <= 1'b1;
      end else begin
        irq_q   <= req_i.level;
        pulse_q <= 1'b0;
      end
    end else if (pulse_q) begin
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_PULSE_RISES: assert property (@(posedge clk) disable iff (rst)
    (fire_i && req_i.kind == TRIG_PULSE) |=> irq_o) else $error("pulse missing"); // R7

  AST_PULSE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (pulse_q && !act) |=> !irq_o) else $error("pulse too long"); // R7

  AST_LEVEL_FOLLOWS_POL: assert property (@(posedge clk) disable iff (rst)
    (fire_i && req_i.kind == TRIG_LEVEL) |=> (irq_o == $past(req_i.level))) else $error("level wrong"); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!act && !pulse_q) |=> $stable(irq_o)) else $error("line moved without event"); // R9

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_route_pkg::*;
#(
  parameter int DEVFN_W  = 8,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8,
  parameter int IRQ_BASE = 32,
  parameter int NUM_INT  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid_i,
  input  logic [DEVFN_W-1:0] evt_devfn_i,
  input  logic [PIN_W-1:0]   evt_pin_i,
  input  logic [NUM_INT-1:0] edge_cfg_i,
  input  logic [NUM_INT-1:0] pol_cfg_i,
  output logic               map_valid_o,
  output logic [NUM_W-1:0]   map_num_o,
  output logic               cpu_irq_o
);

  logic [NUM_W-1:0] num;
  trig_req_t        req;
  logic             valid_q;
  logic [NUM_W-1:0] num_q;

  irq_slot_mapper #(
    .DEVFN_W (DEVFN_W),
    .PIN_W   (PIN_W),
    .NUM_W   (NUM_W),
    .IRQ_BASE(IRQ_BASE)
  ) u_map (
    .devfn_i(evt_devfn_i),
    .pin_i  (evt_pin_i),
    .num_o  (num)
  );

  irq_line_decode #(
    .NUM_W   (NUM_W),
    .IRQ_BASE(IRQ_BASE),
    .NUM_INT (NUM_INT)
  ) u_dec (
    .num_i     (num),
    .edge_cfg_i(edge_cfg_i),
    .pol_cfg_i (pol_cfg_i),
    .req_o     (req)
  );

  irq_trigger u_trig (
    .clk   (clk),
    .rst   (rst),
    .fire_i(evt_valid_i),
    .req_i (req),
    .irq_o (cpu_irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      num_q   <= '0;
    end else begin
      valid_q <= evt_valid_i;
      if (evt_valid_i) num_q <= num;
    end
  end

  assign map_valid_o = valid_q;
  assign map_num_o   = num_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!map_valid_o && !cpu_irq_o && map_num_o == '0)) else $error("reset state"); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    evt_valid_i |=> map_valid_o) else $error("valid lost"); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !evt_valid_i |=> !map_valid_o) else $error("spurious valid"); // R2

endmodule

// File: tb/pci_irq_router_bench.sv
module pci_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [7:0]  evt_devfn = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_cfg = '0;
  logic [31:0] pol_cfg = '0;
  logic        map_valid;
  logic [7:0]  map_num;
  logic        cpu_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pci_irq_router u_pci_irq_router (
    .clk        (clk),
    .rst        (rst),
    .evt_valid_i(evt_valid),
    .evt_devfn_i(evt_devfn),
    .evt_pin_i  (evt_pin),
    .edge_cfg_i (edge_cfg),
    .pol_cfg_i  (pol_cfg),
    .map_valid_o(map_valid),
    .map_num_o  (map_num),
    .cpu_irq_o  (cpu_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected number from the requirements R3..R6
  function automatic int exp_num(input int slot, input int pin);
    if (slot == 5) return 32 + pin;
    if (slot == 6) return 36;
    if (slot == 7) return 37;
    if (slot >= 8 && slot <= 12) return slot - 8 + pin + 38;
    return pin;
  endfunction

  function automatic string req_of(input int slot);
    if (slot == 5) return "R3";
    if (slot == 6 || slot == 7) return "R4";
    if (slot >= 8 && slot <= 12) return "R5";
    return "R6";
  endfunction

  // Present one event at a falling edge; on return the outputs show its result.
  task automatic send(input int slot, input int fn, input int pin);
    @(negedge clk);
    evt_valid = 1'b1;
    evt_devfn = 8'((slot << 3) | (fn & 7));
    evt_pin   = 2'(pin);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(map_valid), 0);
    check("R1 num", int'(map_num), 0);
    check("R1 irq", int'(cpu_irq), 0);
  endtask

  task automatic t_map_sweep();
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        send(s, (s * 3 + p) & 7, p);
        check("R2 valid", int'(map_valid), 1);
        check(req_of(s), int'(map_num), exp_num(s, p));
      end
    end
    idle(1);
    check("R2 idle valid", int'(map_valid), 0);
  endtask

  task automatic t_level();
    edge_cfg = '0;
    pol_cfg  = 32'h0000_0010;  // line 4 high, line 5 low
    send(6, 0, 2);
    check("R8 high", int'(cpu_irq), 1);
    idle(3);
    check("R8 hold high", int'(cpu_irq), 1);
    send(7, 0, 0);
    check("R8 low", int'(cpu_irq), 0);
    idle(2);
    check("R8 hold low", int'(cpu_irq), 0);
  endtask

  task automatic t_pulse();
    edge_cfg = 32'h0000_2001;  // lines 0 and 13
    pol_cfg  = 32'hFFFF_FFFF;  // must not matter in edge mode
    send(5, 0, 0);
    check("R7 pulse high", int'(cpu_irq), 1);
    @(negedge clk);
    check("R7 pulse ends", int'(cpu_irq), 0);
    idle(2);
    check("R7 stays low", int'(cpu_irq), 0);
    // back-to-back: slot 12 pin 3 -> 45 -> line 13, then slot 5 pin 0
    @(negedge clk);
    evt_valid = 1'b1; evt_devfn = 8'(12 << 3); evt_pin = 2'd3;
    @(negedge clk);
    check("R5 num 45", int'(map_num), 45);
    check("R7 first", int'(cpu_irq), 1);
    evt_devfn = 8'(5 << 3); evt_pin = 2'd0;
    @(negedge clk);
    evt_valid = 1'b0;
    check("R7 second", int'(cpu_irq), 1);
    @(negedge clk);
    check("R7 end after pair", int'(cpu_irq), 0);
  endtask

  task automatic t_out_of_range();
    edge_cfg = '0;
    pol_cfg  = 32'h0000_0010;
    send(6, 0, 0);
    check("R8 setup", int'(cpu_irq), 1);
    send(0, 0, 2);
    check("R6 num", int'(map_num), 2);
    check("R9 level kept", int'(cpu_irq), 1);
    send(31, 7, 3);
    check("R9 level kept 2", int'(cpu_irq), 1);
    // pulse followed at once by an untranslated event
    edge_cfg = 32'h0000_0001;
    @(negedge clk);
    evt_valid = 1'b1; evt_devfn = 8'(5 << 3); evt_pin = 2'd0;
    @(negedge clk);
    check("R7 pulse", int'(cpu_irq), 1);
    evt_devfn = 8'(20 << 3); evt_pin = 2'd1;
    @(negedge clk);
    evt_valid = 1'b0;
    check("R9 pulse still ends", int'(cpu_irq), 0);
    @(negedge clk);
    check("R9 stays low", int'(cpu_irq), 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map_sweep();
    t_level();
    t_pulse();
    t_out_of_range();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule